// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable stand-in for a word-wide asynchronous static memory. It has two chip selects of opposite polarity, an output enable, a write enable and one enable for each byte lane. The control pins are sampled on an internal fast clock. From the sampled pins the block decodes one of four modes: standby (deselected and powered down), read, output-muted or write. It then drives the data bus, with a separate drive enable for each byte lane, and stores only the byte lanes that are enabled.

The bus is presented pad-side as a data input, a data output and one drive enable per lane, so that the surrounding logic or the pad ring builds the actual three-state buffer. A write lasts while every enable that it needs is active at the same time. The write is committed when the first of those enables is released. The address, data and lanes committed are the ones sampled on the last cycle of that overlap. The array depth is a parameter, so the model can stand in for a large memory while simulating only a small one. A standby status output marks every powered-down mode.

Top module: `bls_sram_model`

## Requirements
- R1: While reset is low and in the first cycle after it, `standby_o` is 1 and `dq_oe_o` is 2'b00. Every word of the array reads back as zero after reset.
- R2: The outputs reflect the pins sampled at the previous rising clock edge. The device is selected only when `sel_n_i` is 0 and `sel_i` is 1. In any other combination, `standby_o` is 1 and `dq_oe_o` is 2'b00.
- R3: When `lo_en_n_i` and `hi_en_n_i` are both 1, the device is in standby (`standby_o` 1, `dq_oe_o` 2'b00), even while selected.
- R4: Read mode is selected, `we_n_i` 1 and `oe_n_i` 0. Bit 0 of `dq_oe_o` (bus bits 7:0) is 1 exactly when `lo_en_n_i` is 0, and bit 1 (bus bits 15:8) is 1 exactly when `hi_en_n_i` is 0. Each driven lane of `dq_o` carries that lane of the stored word at the sampled address.
- R5: Output-muted mode is selected, `we_n_i` 1, `oe_n_i` 1 and at least one lane enabled. In this mode `dq_oe_o` is 2'b00 and `standby_o` is 0.
- R6: Write mode is selected, `we_n_i` 0 and at least one lane enabled. In this mode `dq_oe_o` is 2'b00 and `standby_o` is 0, whatever the value of `oe_n_i`.
- R7: A write stores bus bits 7:0 only if `lo_en_n_i` was 0, and bits 15:8 only if `hi_en_n_i` was 0. The other lane of the word keeps its old value.
- R8: A write is committed once, when the write overlap is first sampled false. Releasing any one of `sel_n_i`, `sel_i`, `we_n_i` or both lane enables ends it. Data taken from the last overlapping sample wins over earlier data.
- R9: If one lane enable is released while the other keeps the write open, only the lanes enabled in the last overlapping sample are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | AW | Word address |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| we_n_i | input | 1 | Active-low write enable |
| oe_n_i | input | 1 | Active-low output enable |
| lo_en_n_i | input | 1 | Active-low enable, bus bits 7:0 |
| hi_en_n_i | input | 1 | Active-low enable, bus bits 15:8 |
| dq_i | input | 16 | Data arriving from the bus |
| dq_o | output | 16 | Data to drive onto the bus |
| dq_oe_o | output | 2 | Per-lane drive enable (bit 0 = low byte) |
| standby_o | output | 1 | Deselected / powered-down indication |

## Verification
The bench builds the block with AW = 4, a 16-word array. With this depth the whole array can be read back after reset, and the highest address is reachable within a short run. Every chip-select and lane-enable combination is driven, together with each way of ending a write. These include data that changes during the overlap and a lane that is dropped before the end of the write. A reference model in the bench predicts the standby flag, the lane drive enables and the driven data on every cycle.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_MUTED   = 2'd2,
        MODE_WRITE   = 2'd3
    } mode_e;

    // Mode from sampled pins; no_lane is 1 when every lane enable is high.
    function automatic mode_e classify(input logic sel_n, input logic sel,
                                       input logic we_n, input logic oe_n,
                                       input logic no_lane);
        if (sel_n || !sel || no_lane) return MODE_STANDBY;
        if (!we_n)                    return MODE_WRITE;
        if (!oe_n)                    return MODE_READ;
        return MODE_MUTED;
    endfunction

endpackage

// File: rtl/bls_pin_sampler.sv
module bls_pin_sampler #(
    parameter int AW     = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr_i,
    input  logic                    sel_n_i,
    input  logic                    sel_i,
    input  logic                    we_n_i,
    input  logic                    oe_n_i,
    input  logic [LANES-1:0]        lane_n_i,
    input  logic [LANES*LANE_W-1:0] data_i,
    output logic [AW-1:0]           s_addr_o,
    output logic                    s_sel_n_o,
    output logic                    s_sel_o,
    output logic                    s_we_n_o,
    output logic                    s_oe_n_o,
    output logic [LANES-1:0]        s_lane_n_o,
    output logic [LANES*LANE_W-1:0] s_data_o
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic             sel_n;
        logic             sel;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
        logic [DW-1:0]    data;
    } samp_t;

    localparam samp_t IDLE_SAMP = '{
        addr:   '0,
        sel_n:  1'b1,
        sel:    1'b0,
        we_n:   1'b1,
        oe_n:   1'b1,
        lane_n: '1,
        data:   '0
    };

    samp_t smp_d, smp_q;

    always_comb begin
        smp_d        = smp_q;
        smp_d.addr   = addr_i;
        smp_d.sel_n  = sel_n_i;
        smp_d.sel    = sel_i;
        smp_d.we_n   = we_n_i;
        smp_d.oe_n   = oe_n_i;
        smp_d.lane_n = lane_n_i;
        smp_d.data   = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= IDLE_SAMP;
        else        smp_q <= smp_d;
    end

    assign s_addr_o   = smp_q.addr;
    assign s_sel_n_o  = smp_q.sel_n;
    assign s_sel_o    = smp_q.sel;
    assign s_we_n_o   = smp_q.we_n;
    assign s_oe_n_o   = smp_q.oe_n;
    assign s_lane_n_o = smp_q.lane_n;
    assign s_data_o   = smp_q.data;

endmodule

// File: rtl/bls_mode_decode.sv
module bls_mode_decode
    import bls_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_n_i,
    input  logic             sel_i,
    input  logic             we_n_i,
    input  logic             oe_n_i,
    input  logic [LANES-1:0] lane_n_i,
    output mode_e            mode_o,
    output logic             standby_o,
    output logic             overlap_o,
    output logic [LANES-1:0] drive_o
);
    mode_e mode;

    always_comb begin
        mode = classify(sel_n_i, sel_i, we_n_i, oe_n_i, &lane_n_i);
    end

    assign mode_o    = mode;
    assign standby_o = (mode == MODE_STANDBY);
    // Write mode already implies both selects, write enable and one lane.
    assign overlap_o = (mode == MODE_WRITE);

    for (genvar g = 0; g < LANES; g++) begin : g_drive
        assign drive_o[g] = (mode == MODE_READ) && !lane_n_i[g];
    end

endmodule

// File: rtl/bls_write_tracker.sv
module bls_write_tracker #(
    parameter int AW     = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    overlap_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [LANES-1:0]        lane_n_i,
    input  logic [LANES*LANE_W-1:0] data_i,
    output logic                    commit_o,
    output logic [AW-1:0]           c_addr_o,
    output logic [LANES-1:0]        c_lanes_o,
    output logic [LANES*LANE_W-1:0] c_data_o
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic             armed;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] lanes;
        logic [DW-1:0]    data;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d       = trk_q;
        trk_d.armed = overlap_i;
        if (overlap_i) begin
            trk_d.addr  = addr_i;
            trk_d.lanes = ~lane_n_i;
            trk_d.data  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // Falling edge of the overlap: commit the last overlapping sample.
    assign commit_o  = trk_q.armed && !overlap_i;
    assign c_addr_o  = trk_q.addr;
    assign c_lanes_o = trk_q.lanes;
    assign c_data_o  = trk_q.data;

endmodule

// File: rtl/bls_lane_array.sv
module bls_lane_array #(
    parameter int AW     = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [AW-1:0]           wr_addr_i,
    input  logic [LANES-1:0]        wr_lanes_i,
    input  logic [LANES*LANE_W-1:0] wr_data_i,
    input  logic [AW-1:0]           rd_addr_i,
    output logic [LANES*LANE_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells_d [DEPTH];
        logic [LANE_W-1:0] cells_q [DEPTH];

        always_comb begin
            cells_d = cells_q;
            if (wr_en_i && wr_lanes_i[g]) begin
                cells_d[wr_addr_i] = wr_data_i[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) cells_q[k] <= '0;
            end else begin
                cells_q <= cells_d;
            end
        end

        assign rd_data_o[g*LANE_W +: LANE_W] = cells_q[rd_addr_i];
    end

endmodule

// File: rtl/bls_sram_model.sv
module bls_sram_model
    import bls_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr_i,
    input  logic                  sel_n_i,
    input  logic                  sel_i,
    input  logic                  we_n_i,
    input  logic                  oe_n_i,
    input  logic                  lo_en_n_i,
    input  logic                  hi_en_n_i,
    input  logic [2*LANE_W-1:0]   dq_i,
    output logic [2*LANE_W-1:0]   dq_o,
    output logic [1:0]            dq_oe_o,
    output logic                  standby_o
);
    localparam int LANES = 2;
    localparam int DW    = LANES * LANE_W;

    logic [AW-1:0]    s_addr;
    logic             s_sel_n, s_sel, s_we_n, s_oe_n;
    logic [LANES-1:0] s_lane_n;
    logic [DW-1:0]    s_data;

    mode_e            mode;
    logic             overlap;
    logic [LANES-1:0] drive;

    logic             commit;
    logic [AW-1:0]    c_addr;
    logic [LANES-1:0] c_lanes;
    logic [DW-1:0]    c_data;
    logic [DW-1:0]    rd_data;

    bls_pin_sampler #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .sel_n_i    (sel_n_i),
        .sel_i      (sel_i),
        .we_n_i     (we_n_i),
        .oe_n_i     (oe_n_i),
        .lane_n_i   ({hi_en_n_i, lo_en_n_i}),
        .data_i     (dq_i),
        .s_addr_o   (s_addr),
        .s_sel_n_o  (s_sel_n),
        .s_sel_o    (s_sel),
        .s_we_n_o   (s_we_n),
        .s_oe_n_o   (s_oe_n),
        .s_lane_n_o (s_lane_n),
        .s_data_o   (s_data)
    );

    bls_mode_decode #(.LANES(LANES)) u_dec (
        .sel_n_i   (s_sel_n),
        .sel_i     (s_sel),
        .we_n_i    (s_we_n),
        .oe_n_i    (s_oe_n),
        .lane_n_i  (s_lane_n),
        .mode_o    (mode),
        .standby_o (standby_o),
        .overlap_o (overlap),
        .drive_o   (drive)
    );

    bls_write_tracker #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .overlap_i (overlap),
        .addr_i    (s_addr),
        .lane_n_i  (s_lane_n),
        .data_i    (s_data),
        .commit_o  (commit),
        .c_addr_o  (c_addr),
        .c_lanes_o (c_lanes),
        .c_data_o  (c_data)
    );

    bls_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (commit),
        .wr_addr_i  (c_addr),
        .wr_lanes_i (c_lanes),
        .wr_data_i  (c_data),
        .rd_addr_i  (s_addr),
        .rd_data_o  (rd_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign dq_o[g*LANE_W +: LANE_W] = drive[g] ? rd_data[g*LANE_W +: LANE_W] : '0;
    end
    assign dq_oe_o = drive;

    logic unused_mode;
    assign unused_mode = ^mode;

endmodule

// File: rtl/bls_sram_checker.sv
module bls_sram_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_n_i,
    input logic       sel_i,
    input logic       we_n_i,
    input logic       oe_n_i,
    input logic       lo_en_n_i,
    input logic       hi_en_n_i,
    input logic [1:0] dq_oe_o,
    input logic       standby_o
);
    logic picked;
    logic lane_any;
    assign picked   = !sel_n_i && sel_i;
    assign lane_any = !(lo_en_n_i && hi_en_n_i);

    a_r2_deselect_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !picked |=> (standby_o && dq_oe_o == 2'b00));

    a_r3_no_lane_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en_n_i && hi_en_n_i) |=> (standby_o && dq_oe_o == 2'b00));

    a_r4_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && lane_any && we_n_i && !oe_n_i)
        |=> (dq_oe_o == ~{$past(hi_en_n_i), $past(lo_en_n_i)} && !standby_o));

    a_r5_muted_active: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && lane_any && we_n_i && oe_n_i) |=> (!standby_o && dq_oe_o == 2'b00));

    a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && lane_any && !we_n_i) |=> (!standby_o && dq_oe_o == 2'b00));

endmodule

bind bls_sram_model bls_sram_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_i   (sel_n_i),
    .sel_i     (sel_i),
    .we_n_i    (we_n_i),
    .oe_n_i    (oe_n_i),
    .lo_en_n_i (lo_en_n_i),
    .hi_en_n_i (hi_en_n_i),
    .dq_oe_o   (dq_oe_o),
    .standby_o (standby_o)
);

// File: tb/tb_bls_sram_model.sv
module tb_bls_sram_model;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 0;
    logic rst_n = 0;
    logic [AW-1:0] addr = '0;
    logic sel_n = 1, sel = 0, we_n = 1, oe_n = 1, lo_n = 1, hi_n = 1;
    logic [15:0] din = '0;
    logic [15:0] dq_o;
    logic [1:0]  dq_oe;
    logic        standby;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bls_sram_model #(.AW(AW), .LANE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .sel_n_i(sel_n), .sel_i(sel),
        .we_n_i(we_n), .oe_n_i(oe_n), .lo_en_n_i(lo_n), .hi_en_n_i(hi_n),
        .dq_i(din), .dq_o(dq_o), .dq_oe_o(dq_oe), .standby_o(standby)
    );

    // Reference model: sampled pins, last overlapping sample, array.
    logic [15:0] mdl [DEPTH];
    logic [AW-1:0] c_addr, p_addr;
    logic c_sel_n, c_sel, c_we_n, c_oe_n, c_lo_n, c_hi_n;
    logic [15:0] c_din, p_din;
    logic p_lo, p_hi, pov;

    function automatic bit ov_of(input logic sn, input logic s, input logic w,
                                 input logic l, input logic h);
        return !sn && s && !w && !(l && h);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mdl[k] <= '0;
            c_addr <= '0; c_sel_n <= 1; c_sel <= 0; c_we_n <= 1; c_oe_n <= 1;
            c_lo_n <= 1; c_hi_n <= 1; c_din <= '0; pov <= 0;
            p_addr <= '0; p_din <= '0; p_lo <= 0; p_hi <= 0;
        end else begin
            if (pov && !ov_of(c_sel_n, c_sel, c_we_n, c_lo_n, c_hi_n)) begin
                if (p_lo) mdl[p_addr][7:0]  <= p_din[7:0];
                if (p_hi) mdl[p_addr][15:8] <= p_din[15:8];
            end
            pov <= ov_of(c_sel_n, c_sel, c_we_n, c_lo_n, c_hi_n);
            if (ov_of(c_sel_n, c_sel, c_we_n, c_lo_n, c_hi_n)) begin
                p_addr <= c_addr; p_din <= c_din; p_lo <= !c_lo_n; p_hi <= !c_hi_n;
            end
            c_addr <= addr; c_sel_n <= sel_n; c_sel <= sel; c_we_n <= we_n;
            c_oe_n <= oe_n; c_lo_n <= lo_n; c_hi_n <= hi_n; c_din <= din;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            bit exp_sb;
            logic [1:0] exp_oe;
            if (c_sel_n || !c_sel)      tag = "R2";
            else if (c_lo_n && c_hi_n)  tag = "R3";
            else if (!c_we_n)           tag = "R6";
            else if (!c_oe_n)           tag = "R4";
            else                        tag = "R5";
            exp_sb = (tag == "R2" || tag == "R3");
            exp_oe = (tag == "R4") ? {!c_hi_n, !c_lo_n} : 2'b00;
            compared++;
            if (standby !== exp_sb) begin
                mismatched++;
                $display("FAIL %s standby got %0b exp %0b", tag, standby, exp_sb);
            end
            compared++;
            if (dq_oe !== exp_oe) begin
                mismatched++;
                $display("FAIL %s dq_oe got %b exp %b", tag, dq_oe, exp_oe);
            end
            if (exp_oe[0]) begin
                compared++;
                if (dq_o[7:0] !== mdl[c_addr][7:0]) begin
                    mismatched++;
                    $display("FAIL R4 low lane got %h exp %h", dq_o[7:0], mdl[c_addr][7:0]);
                end
            end
            if (exp_oe[1]) begin
                compared++;
                if (dq_o[15:8] !== mdl[c_addr][15:8]) begin
                    mismatched++;
                    $display("FAIL R4 high lane got %h exp %h", dq_o[15:8], mdl[c_addr][15:8]);
                end
            end
        end
    end

    task automatic drive(input logic [AW-1:0] a, input logic sn, input logic s,
                         input logic w, input logic o, input logic l,
                         input logic h, input logic [15:0] d);
        @(posedge clk);
        #2;
        addr = a; sel_n = sn; sel = s; we_n = w; oe_n = o; lo_n = l; hi_n = h; din = d;
    endtask

    task automatic idle();
        drive('0, 1, 0, 1, 1, 1, 1, 16'h0);
    endtask

    // Full-word read at address a, compared with a value derived from the requirements.
    task automatic read_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
        drive(a, 0, 1, 1, 0, 0, 0, 16'h0);
        @(posedge clk);
        @(negedge clk);
        compared++;
        if (dq_o !== exp || dq_oe !== 2'b11) begin
            mismatched++;
            $display("FAIL %s read @%0d got %h/%b exp %h/11", tag, a, dq_o, dq_oe, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compared++;
        if (standby !== 1'b1 || dq_oe !== 2'b00) begin
            mismatched++;
            $display("FAIL R1 reset outputs got %0b/%b exp 1/00", standby, dq_oe);
        end
        #2 rst_n = 1;
        @(negedge clk);
        compared++;
        if (standby !== 1'b1 || dq_oe !== 2'b00) begin
            mismatched++;
            $display("FAIL R1 first cycle got %0b/%b exp 1/00", standby, dq_oe);
        end
        for (int k = 0; k < DEPTH; k++) read_chk(k[AW-1:0], 16'h0000, "R1");

        // Full word, ended by write enable (R8).
        drive(3, 0, 1, 0, 1, 0, 0, 16'hA5C3);
        drive(3, 0, 1, 0, 1, 0, 0, 16'hA5C3);
        drive(3, 0, 1, 1, 1, 0, 0, 16'h0);
        read_chk(3, 16'hA5C3, "R8");
        // Lane writes (R7).
        drive(3, 0, 1, 0, 1, 0, 1, 16'h1111);
        drive(3, 0, 1, 1, 1, 0, 1, 16'h0);
        read_chk(3, 16'hA511, "R7");
        drive(3, 0, 1, 0, 1, 1, 0, 16'h2222);
        drive(3, 0, 1, 1, 1, 1, 0, 16'h0);
        read_chk(3, 16'h2211, "R7");
        // Partial-lane reads (R4), per-cycle compare.
        drive(3, 0, 1, 1, 0, 0, 1, 16'h0);
        drive(3, 0, 1, 1, 0, 1, 0, 16'h0);
        // Termination by each enable (R8).
        drive(5, 0, 1, 0, 1, 0, 0, 16'hFFFF);
        drive(5, 1, 1, 0, 1, 0, 0, 16'h0);
        idle();
        read_chk(5, 16'hFFFF, "R8");
        drive(6, 0, 1, 0, 1, 0, 0, 16'h6E6E);
        drive(6, 0, 0, 0, 1, 0, 0, 16'h0);
        idle();
        read_chk(6, 16'h6E6E, "R8");
        drive(7, 0, 1, 0, 1, 0, 0, 16'h7171);
        drive(7, 0, 1, 0, 1, 1, 1, 16'h0);
        idle();
        read_chk(7, 16'h7171, "R8");
        // Output enable low during write is ignored (R6).
        drive(8, 0, 1, 0, 0, 0, 0, 16'h1234);
        drive(8, 0, 1, 0, 0, 0, 0, 16'h1234);
        drive(8, 0, 1, 1, 1, 0, 0, 16'h0);
        read_chk(8, 16'h1234, "R6");
        // Data changes during the overlap: last sample wins (R8).
        drive(9, 0, 1, 0, 1, 0, 0, 16'h1111);
        drive(9, 0, 1, 0, 1, 0, 0, 16'h2222);
        drive(9, 0, 1, 1, 1, 0, 0, 16'h0);
        read_chk(9, 16'h2222, "R8");
        // High lane dropped before the end (R9).
        drive(10, 0, 1, 0, 1, 0, 0, 16'hABCD);
        drive(10, 0, 1, 0, 1, 0, 1, 16'hABCD);
        drive(10, 0, 1, 1, 1, 0, 1, 16'h0);
        read_chk(10, 16'h00CD, "R9");
        // Deselect combinations with read pins (R2), no lanes (R3), muted (R5).
        drive(3, 1, 1, 1, 0, 0, 0, 16'h0);
        drive(3, 0, 0, 1, 0, 0, 0, 16'h0);
        drive(3, 1, 0, 1, 0, 0, 0, 16'h0);
        drive(3, 0, 1, 1, 0, 1, 1, 16'h0);
        drive(3, 0, 1, 0, 1, 1, 1, 16'hDEAD);
        drive(3, 0, 1, 1, 1, 1, 1, 16'h0);
        read_chk(3, 16'h2211, "R3");
        drive(3, 0, 1, 1, 1, 0, 0, 16'h0);
        drive(3, 0, 1, 1, 1, 0, 1, 16'h0);
        // Top address.
        drive(15, 0, 1, 0, 1, 0, 0, 16'hBEEF);
        drive(15, 0, 1, 1, 0, 0, 0, 16'h0);
        read_chk(15, 16'hBEEF, "R7");
        read_chk(0, 16'h0000, "R7");
        idle();
        idle();
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule